// File: doc/BRIEF.md
# Binary BCH Error-Locator Solver

This block takes the syndromes of a binary BCH codeword over GF(2^13) and finds the error-locator polynomial sigma(x). A decoder first computes the syndromes, then runs this solver, and then passes the resulting sigma(x) to a root search. The solver uses the binary form of the iterative Berlekamp procedure. Because even syndromes in a binary code are squares of odd ones, each row moves the row index mu by two, so only t rows are needed for a code that corrects up to t errors.

For each row the block keeps four things: the polynomial, its discrepancy, its degree and its delta. On a nonzero discrepancy it picks an earlier pivot row and folds a scaled, shifted copy of that row's polynomial into the new row. It also counts the rows whose discrepancy is zero. When that count reaches a bound set by t and the current degree, the block stops early. All field products go through one shared bit-serial multiplier. A division by the pivot's discrepancy is done by raising it to the power 2^13 - 2.

The user drives t and the syndromes, pulses start, waits while busy is high, and reads sigma and its degree when done pulses.

Top module: `bm_locator_solver`

## Requirements
- R1: While rst is high, busy, done, sigma_out and deg_out read zero at the next clock edge.
- R2: A start seen while busy is low captures t_in and syn_in, and busy reads 1 after that clock edge.
- R3: done is high for exactly one cycle, and busy falls on the same edge. sigma_out and deg_out change only on that edge and hold their value until the next done.
- R4: Whenever done is high, coefficient 0 of sigma_out (bits [12:0]) equals 1.
- R5: Syndrome j sits in syn_in bits [(j-1)*13 +: 13] and equals the XOR over all error positions p of alpha^(j*p mod 8191). The field is GF(2^13) with x^13+x^4+x^3+x+1, and alpha = x. For 1 <= v <= t errors, sigma_out holds the product of (1 + alpha^p x), with coefficient k at bits [k*13 +: 13], and deg_out equals v.
- R6: With all syndromes zero, the result is sigma = 1 and degree 0.
- R7: The solver exits early once the count of zero discrepancies equals floor((t-L-1)/2) + 2 when t-L-1 is odd, or + 1 when it is even, where L is the current degree. With t = 4 and all syndromes zero, done is seen no more than 8 clock cycles after the edge that accepts start.
- R8: Syndromes with an index above 2t have no effect on the result.
- R9: A start seen while busy is high is ignored, and the run in progress returns the result of the syndromes captured when it began.
- R10: Changing syn_in or t_in after start has been accepted does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a solve; accepted only when idle |
| t_in | input | $clog2(T_MAX+1) | Correction capability t, 1..T_MAX |
| syn_in | input | 2*T_MAX*M | Syndromes S1..S2T_MAX, S1 in the low bits |
| busy | output | 1 | High from the accepted start until done |
| done | output | 1 | One-cycle pulse when the result is valid |
| sigma_out | output | (T_MAX+1)*M | Locator coefficients, sigma_0 in the low bits |
| deg_out | output | $clog2(T_MAX+1)+1 | Degree of the locator |

## Verification
The bench drives syndromes built from chosen error positions, including positions 0 and 8190 at the two ends of the codeword. It covers every error count from zero to t. A wrong pivot choice or a wrong shift amount would give a polynomial whose coefficients do not match the product of the locator terms. An off-by-one in the early-exit bound would either return before the last nonzero discrepancy, producing a wrong sigma, or run the whole loop, which the latency bound on the all-zero case catches. Runs with t below the maximum put junk in the high syndromes, and another run changes the inputs and pulses start during a solve; a block that read its inputs live, or restarted, would return a different polynomial.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int          GF_M_DEF    = 13;
  localparam logic [13:0] GF_POLY_DEF = 14'h201B;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ITER, ST_INV_SQ, ST_INV_ML, ST_FACT,
    ST_UPD, ST_DELTA, ST_DISC, ST_FIN
  } bm_state_e;
endpackage

// File: rtl/gf_serial_mul.sv
module gf_serial_mul #(
  parameter int         M    = bm_pkg::GF_M_DEF,
  parameter logic [M:0] POLY = bm_pkg::GF_POLY_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] prod,
  output logic         rdy
);
  localparam int CW = $clog2(M + 1);

  logic [M-1:0]  a_q, b_q, acc_q, acc_step;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  // Horner step, most significant multiplier bit first
  always_comb begin
    acc_step = {acc_q[M-2:0], 1'b0};
    if (acc_q[M-1]) acc_step = acc_step ^ POLY[M-1:0];
    if (b_q[M-1])   acc_step = acc_step ^ a_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; acc_q <= '0; cnt_q <= '0;
      run_q <= 1'b0; rdy <= 1'b0; prod <= '0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        a_q <= a; b_q <= b; acc_q <= '0;
        cnt_q <= CW'(M); run_q <= 1'b1;
      end else if (run_q) begin
        acc_q <= acc_step;
        b_q   <= {b_q[M-2:0], 1'b0};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          rdy   <= 1'b1;
          prod  <= acc_step;
        end
      end
    end
  end
endmodule

// File: rtl/bm_pivot_pick.sv
module bm_pivot_pick #(
  parameter int ROWS = 6,
  parameter int IW   = 6,
  parameter int RW   = 3
) (
  input  logic [ROWS-1:0]    nz,
  input  logic [ROWS*IW-1:0] deltas,
  input  logic [RW-1:0]      cur,
  output logic [RW-1:0]      pick
);
  logic signed [IW-1:0] best, dj;

  // earliest row with nonzero discrepancy and strictly largest delta
  always_comb begin
    pick = '0;
    best = {IW{1'b1}};
    for (int j = 0; j < ROWS; j++) begin
      dj = deltas[j*IW +: IW];
      if ((RW'(j) < cur) && nz[j] && (dj > best)) begin
        best = dj;
        pick = RW'(j);
      end
    end
  end
endmodule

// File: rtl/bm_locator_solver.sv
module bm_locator_solver import bm_pkg::*; #(
  parameter int         M     = GF_M_DEF,
  parameter int         T_MAX = 4,
  parameter logic [M:0] POLY  = GF_POLY_DEF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [$clog2(T_MAX+1)-1:0]   t_in,
  input  logic [2*T_MAX*M-1:0]         syn_in,
  output logic                         busy,
  output logic                         done,
  output logic [(T_MAX+1)*M-1:0]       sigma_out,
  output logic [$clog2(T_MAX+1):0]     deg_out
);
  localparam int ROWS = T_MAX + 2;
  localparam int RW   = $clog2(ROWS);
  localparam int IW   = $clog2(4*T_MAX + 8) + 1;
  localparam int KW   = $clog2(M + 2*T_MAX + 2);
  localparam int NS   = 2 * T_MAX;
  localparam int TW   = $clog2(T_MAX + 1);
  localparam int DW   = TW + 1;

  bm_state_e st;
  logic [RW-1:0] i_q, ro_q, fin_q, ip1, ro_c;
  logic [TW-1:0] t_q;
  logic [M-1:0]  syn_q [1:NS];
  logic [M-1:0]  sig_q [0:ROWS-1][0:T_MAX];
  logic [M-1:0]  dsc_q [0:ROWS-1];
  logic signed [IW-1:0] len_q [0:ROWS-1];
  logic signed [IW-1:0] dl_q  [0:ROWS-1];
  logic signed [IW-1:0] zc_q, diff_q, diff_c, cand, newlen, vv, lim;
  logic [KW-1:0] k_q;
  logic [M-1:0]  s_q, r_q, f_q, acc_q, snext, sdisc, mprod;
  logic [M-1:0]  ma_q, mb_q;
  logic          mwait_q, mgo_q, mrdy;
  logic [ROWS-1:0]    nz_v;
  logic [ROWS*IW-1:0] dl_v;
  int pos;

  function automatic logic signed [IW-1:0] mu_of(input logic [RW-1:0] r);
    if (r == '0) return {IW{1'b1}};
    return IW'(2 * (int'(r) - 1));
  endfunction

  assign ip1 = i_q + RW'(1);

  for (genvar g = 0; g < ROWS; g++) begin : g_pack
    assign nz_v[g]           = |dsc_q[g];
    assign dl_v[g*IW +: IW]  = dl_q[g];
  end

  bm_pivot_pick #(.ROWS(ROWS), .IW(IW), .RW(RW)) u_pick (
    .nz(nz_v), .deltas(dl_v), .cur(i_q), .pick(ro_c)
  );

  gf_serial_mul #(.M(M), .POLY(POLY)) u_mul (
    .clk(clk), .rst(rst), .go(mgo_q), .a(ma_q), .b(mb_q),
    .prod(mprod), .rdy(mrdy)
  );

  always_comb begin
    diff_c = mu_of(i_q) - mu_of(ro_c);
    cand   = len_q[ro_c] + diff_c;
    newlen = (len_q[i_q] > cand) ? len_q[i_q] : cand;
    vv     = IW'(int'(t_q) - int'(len_q[i_q]) - 1);
    lim    = IW'(int'(vv) / 2 + (vv[0] ? 2 : 1));
    pos    = int'(k_q) + int'(diff_q);
    snext  = '0;
    sdisc  = '0;
    for (int j = 1; j <= NS; j++) begin
      if (j == 2*int'(i_q) + 1)               snext = syn_q[j];
      if (j == 2*int'(i_q) + 1 - int'(k_q))   sdisc = syn_q[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; busy <= 1'b0; done <= 1'b0;
      sigma_out <= '0; deg_out <= '0;
      i_q <= '0; ro_q <= '0; fin_q <= '0; t_q <= '0;
      zc_q <= '0; diff_q <= '0; k_q <= '0;
      s_q <= '0; r_q <= '0; f_q <= '0; acc_q <= '0;
      mwait_q <= 1'b0; mgo_q <= 1'b0; ma_q <= '0; mb_q <= '0;
      for (int j = 1; j <= NS; j++) syn_q[j] <= '0;
      for (int r = 0; r < ROWS; r++) begin
        dsc_q[r] <= '0; len_q[r] <= '0; dl_q[r] <= '0;
        for (int c = 0; c <= T_MAX; c++) sig_q[r][c] <= '0;
      end
    end else begin
      done  <= 1'b0;
      mgo_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          t_q <= t_in;
          for (int j = 1; j <= NS; j++) syn_q[j] <= syn_in[(j-1)*M +: M];
          for (int r = 0; r < ROWS; r++) begin
            dsc_q[r] <= '0; len_q[r] <= '0; dl_q[r] <= '0;
            for (int c = 0; c <= T_MAX; c++) sig_q[r][c] <= '0;
          end
          sig_q[0][0] <= M'(1);  sig_q[1][0] <= M'(1);
          dsc_q[0]    <= M'(1);  dsc_q[1]    <= syn_in[M-1:0];
          dl_q[0]     <= {IW{1'b1}};
          zc_q <= '0; i_q <= RW'(1); busy <= 1'b1; st <= ST_ITER;
        end
        ST_ITER: begin
          for (int c = 0; c <= T_MAX; c++) sig_q[ip1][c] <= sig_q[i_q][c];
          if (dsc_q[i_q] == '0) begin
            zc_q <= zc_q + IW'(1);
            len_q[ip1] <= len_q[i_q];
            if (int'(zc_q) + 1 == int'(lim)) begin
              fin_q <= i_q; st <= ST_FIN;
            end else st <= ST_DELTA;
          end else begin
            len_q[ip1] <= newlen;
            ro_q <= ro_c; diff_q <= diff_c;
            s_q <= dsc_q[ro_c]; r_q <= M'(1); k_q <= KW'(1);
            st <= ST_INV_SQ;
          end
        end
        ST_INV_SQ:
          if (!mwait_q) begin
            mgo_q <= 1'b1; ma_q <= s_q; mb_q <= s_q; mwait_q <= 1'b1;
          end else if (mrdy) begin
            mwait_q <= 1'b0; s_q <= mprod; st <= ST_INV_ML;
          end
        ST_INV_ML:
          if (!mwait_q) begin
            mgo_q <= 1'b1; ma_q <= r_q; mb_q <= s_q; mwait_q <= 1'b1;
          end else if (mrdy) begin
            mwait_q <= 1'b0; r_q <= mprod;
            if (int'(k_q) == M - 1) st <= ST_FACT;
            else begin k_q <= k_q + KW'(1); st <= ST_INV_SQ; end
          end
        ST_FACT:
          if (!mwait_q) begin
            mgo_q <= 1'b1; ma_q <= dsc_q[i_q]; mb_q <= r_q; mwait_q <= 1'b1;
          end else if (mrdy) begin
            mwait_q <= 1'b0; f_q <= mprod; k_q <= '0; st <= ST_UPD;
          end
        ST_UPD:
          if (!mwait_q) begin
            mgo_q <= 1'b1; ma_q <= f_q; mb_q <= sig_q[ro_q][k_q]; mwait_q <= 1'b1;
          end else if (mrdy) begin
            mwait_q <= 1'b0;
            for (int c = 0; c <= T_MAX; c++)
              if (c == pos) sig_q[ip1][c] <= sig_q[ip1][c] ^ mprod;
            if (int'(k_q) >= int'(len_q[ro_q]) || int'(k_q) >= T_MAX) st <= ST_DELTA;
            else k_q <= k_q + KW'(1);
          end
        ST_DELTA: begin
          dl_q[ip1] <= mu_of(ip1) - len_q[ip1];
          if (int'(i_q) == int'(t_q)) begin
            fin_q <= ip1; st <= ST_FIN;
          end else begin
            acc_q <= snext; k_q <= KW'(1);
            if (int'(len_q[ip1]) <= 0) begin
              dsc_q[ip1] <= snext; i_q <= ip1; st <= ST_ITER;
            end else st <= ST_DISC;
          end
        end
        ST_DISC:
          if (!mwait_q) begin
            mgo_q <= 1'b1; ma_q <= sig_q[ip1][k_q]; mb_q <= sdisc; mwait_q <= 1'b1;
          end else if (mrdy) begin
            mwait_q <= 1'b0;
            if (int'(k_q) >= int'(len_q[ip1]) || int'(k_q) >= T_MAX) begin
              dsc_q[ip1] <= acc_q ^ mprod; i_q <= ip1; st <= ST_ITER;
            end else begin
              acc_q <= acc_q ^ mprod; k_q <= k_q + KW'(1);
            end
          end
        ST_FIN: begin
          for (int c = 0; c <= T_MAX; c++) sigma_out[c*M +: M] <= sig_q[fin_q][c];
          deg_out <= DW'(len_q[fin_q]);
          done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bm_locator_checker.sv
module bm_locator_checker #(
  parameter int M     = 13,
  parameter int T_MAX = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic [(T_MAX+1)*M-1:0] sigma_out
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!busy && !done));

  p_start_takes_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_hold_result_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done || $stable(sigma_out)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(sigma_out) && !busy));

  p_lead_coef_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (sigma_out[M-1:0] == M'(1)));
endmodule

bind bm_locator_solver bm_locator_checker #(.M(M), .T_MAX(T_MAX)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .sigma_out(sigma_out)
);

// File: tb/bm_locator_solver_test.sv
module bm_locator_solver_test;
  localparam int M = 13;
  localparam int T = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] t_in = '0;
  logic [2*T*M-1:0] syn_in = '0;
  logic busy, done;
  logic [(T+1)*M-1:0] sigma_out;
  logic [3:0] deg_out;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  bm_locator_solver uut (
    .clk(clk), .rst(rst), .start(start), .t_in(t_in), .syn_in(syn_in),
    .busy(busy), .done(done), .sigma_out(sigma_out), .deg_out(deg_out)
  );

  function automatic logic [12:0] gmul(input logic [12:0] a, input logic [12:0] b);
    logic [25:0] p;
    p = '0;
    for (int i = 0; i < 13; i++) if (b[i]) p ^= (26'(a) << i);
    for (int i = 25; i >= 13; i--) if (p[i]) p ^= (26'(14'h201B) << (i - 13));
    return p[12:0];
  endfunction

  function automatic logic [12:0] apow(input int n);
    logic [12:0] r, b;
    int e;
    r = 13'd1; b = 13'd2; e = n % 8191;
    while (e > 0) begin
      if (e % 2 == 1) r = gmul(r, b);
      b = gmul(b, b);
      e = e / 2;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input int pos[$], input int tt, input bit junk,
                          input bit disturb, input int max_lat, input string req);
    logic [2*T*M-1:0] sv;
    logic [12:0] e [0:T];
    logic [(T+1)*M-1:0] exp_sig, held;
    logic [12:0] s, x;
    int lat, bad_busy;
    sv = '0;
    for (int j = 1; j <= 2*T; j++) begin
      s = '0;
      foreach (pos[q]) s ^= apow(j * pos[q]);
      if (junk && j > 2*tt) s = 13'h1ABC ^ 13'(j);
      sv[(j-1)*M +: M] = s;
    end
    for (int k = 0; k <= T; k++) e[k] = (k == 0) ? 13'd1 : 13'd0;
    foreach (pos[q]) begin
      x = apow(pos[q]);
      for (int k = T; k >= 1; k--) e[k] ^= gmul(x, e[k-1]);
    end
    for (int k = 0; k <= T; k++) exp_sig[k*M +: M] = e[k];

    @(negedge clk);
    syn_in = sv; t_in = 3'(tt); start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; bad_busy = 0;
    chk(busy === 1'b1, "R2", "busy after start", 96'(busy), 96'd1);
    if (disturb) begin
      syn_in = ~sv; t_in = 3'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0; lat++;
    end
    while (done !== 1'b1 && lat < 20000) begin
      if (busy !== 1'b1) bad_busy++;
      @(negedge clk);
      lat++;
    end
    chk(lat < 20000, req, "done timeout", 96'(lat), 96'd20000);
    chk(bad_busy == 0, "R3", "busy dropped early", 96'(bad_busy), 96'd0);
    chk(busy === 1'b0, "R3", "busy with done", 96'(busy), 96'd0);
    chk(sigma_out === exp_sig, req, "sigma", 96'(sigma_out), 96'(exp_sig));
    chk(deg_out === 4'(pos.size()), req, "degree", 96'(deg_out), 96'(pos.size()));
    chk(sigma_out[M-1:0] === 13'd1, "R4", "sigma_0", 96'(sigma_out[M-1:0]), 96'd1);
    if (max_lat > 0)
      chk(lat <= max_lat, "R7", "early exit latency", 96'(lat), 96'(max_lat));
    held = sigma_out;
    @(negedge clk);
    chk(done === 1'b0, "R3", "done pulse width", 96'(done), 96'd0);
    chk(sigma_out === held, "R3", "result hold", 96'(sigma_out), 96'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", 96'({busy, done}), 96'd0);
    chk(sigma_out === '0 && deg_out === '0, "R1", "outputs in reset", 96'(sigma_out), 96'd0);
    rst = 1'b0;
    run_case('{}, 4, 1'b0, 1'b0, 8, "R6");
    run_case('{5}, 4, 1'b0, 1'b0, 0, "R5");
    run_case('{0, 8190}, 4, 1'b0, 1'b0, 0, "R5");
    run_case('{17, 402, 7777}, 4, 1'b0, 1'b0, 0, "R5");
    run_case('{3, 1000, 4096, 8000}, 4, 1'b0, 1'b0, 0, "R5");
    run_case('{12, 345}, 2, 1'b1, 1'b0, 0, "R8");
    run_case('{6000}, 2, 1'b1, 1'b0, 0, "R8");
    run_case('{1, 2, 3, 4}, 4, 1'b0, 1'b1, 0, "R9");
    run_case('{250, 5500}, 4, 1'b0, 1'b1, 0, "R10");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule